// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the device side of an asynchronous/synchronous parallel flash bus. It oversamples the external active-low control pins (chip select, output enable, write enable, address-valid, hardware reset) and the bus clock pin with a fast internal clock. From these samples it classifies every bus cycle, latches the address, feeds a simple internal read port and turns completed write cycles into one-cycle command strobes.

The address latch has two modes, chosen by a configuration input that is only taken while the bus is idle. In asynchronous mode the latch follows the address pins while address-valid is low and holds once it rises. In synchronous mode the latch takes the address once per address-valid window, on whichever comes first: the rising edge of address-valid, or a rising bus clock edge while address-valid is low. A synchronous capture starts a stall indication that lasts a fixed number of internal cycles, standing for the initial read latency.

The data bus and the stall pin are expressed as value/enable pairs, so the pad ring owns the actual tri-state drivers.

Top module: `flash_bus_front`

## Requirements
- R1: `bus_op` reports the cycle class from the synchronized pins with this priority: reset pin low gives 0 (reset); otherwise select high gives 1 (standby); otherwise write-enable low with output-enable high gives 4 (write); output-enable low with write-enable high gives 3 (read); any other combination gives 2 (output disabled).
- R2: During a read (`bus_op`=3) `data_oe` is 1 and `data_out` equals `mem_rdata`, which the internal port returns for `mem_addr`, the latched address.
- R3: During a write `data_oe` is 0; when the write ends through the first rising edge of write-enable or select (or both together), `cmd_valid` pulses for one cycle carrying the address and data seen on the pins during the write.
- R4: The second rising edge that closes the same write window produces no further strobe, even if the data pins changed between the two edges; exactly one strobe is issued per window.
- R5: In asynchronous mode (`cfg_sync`=0 in effect) the latched address follows `pin_addr` while `pin_alat_n` is low and holds its value once `pin_alat_n` is high.
- R6: In synchronous mode the address is captured only on the first of: a rising `pin_alat_n` edge, or a rising `pin_bclk` edge while `pin_alat_n` is low; capture needs select low, write-enable high and reset pin high. Later events are ignored until `pin_alat_n` falls again.
- R7: Whenever output-enable is high, `data_oe` and `stall_oe` are both 0.
- R8: With the reset pin low, or with select high, `data_oe` and `stall_oe` are 0; the reset pin also ends any stall in progress.
- R9: `stall_oe` is 1 only during reads in synchronous mode; it stays 0 during asynchronous reads.
- R10: After a synchronous capture `stall_out` is 1 for exactly `RD_LATENCY` internal clock cycles, then 0.
- R11: After `rst_n` the mode is asynchronous; `cfg_sync` is loaded only while `bus_op` is reset or standby, and a change during an active cycle has no effect until the bus next goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast system clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_sync | input | 1 | Requested latch mode: 1 synchronous, 0 asynchronous (quasi-static) |
| pin_hrst_n | input | 1 | External hardware reset pin, active low |
| pin_sel_n | input | 1 | External chip select, active low |
| pin_rden_n | input | 1 | External output enable, active low |
| pin_wren_n | input | 1 | External write enable, active low |
| pin_alat_n | input | 1 | External address-valid strobe, active low |
| pin_bclk | input | 1 | External bus clock pin |
| pin_addr | input | AW | External address pins |
| data_in | input | DW | Data bus value seen at the pads |
| data_out | output | DW | Data bus value to drive |
| data_oe | output | 1 | Data bus output enable (0 releases the bus) |
| stall_out | output | 1 | Stall value: 1 while read data is not yet valid |
| stall_oe | output | 1 | Stall pin output enable |
| mem_addr | output | AW | Latched address to the internal read port |
| mem_rdata | input | DW | Read port data for `mem_addr`, same cycle |
| cmd_valid | output | 1 | One-cycle strobe of a completed write |
| cmd_addr | output | AW | Address carried by the strobe |
| cmd_data | output | DW | Data carried by the strobe |
| bus_op | output | 3 | Current cycle class (encoding in R1) |

## Verification
The hardest state to reach from the ports is a disarmed synchronous latch: a capture has already happened in the current address-valid window and further bus clock edges and the closing address-valid edge must all be ignored. The stimulus gets there by holding address-valid low, delivering one bus clock edge, then changing the address and delivering both a second bus clock edge and the address-valid rising edge, observing through the read data that the first address is still in force. A second hard case is the back edge of a write window after the data pins have changed, reached by raising the two enables several internal cycles apart with a data change in between and counting strobes.

// File: rtl/fbf_pkg.sv
// Shared types and helpers of the flash bus front end.
// Assumes control pins are active low and already synchronized.
package fbf_pkg;

    // Cycle class; the numeric codes are visible on the bus_op port.
    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_STANDBY = 3'd1,
        OP_OUTDIS  = 3'd2,
        OP_READ    = 3'd3,
        OP_WRITE   = 3'd4
    } bus_op_t;

    // Bit positions of the control pins inside the synchronizer bus.
    localparam int CI_HRST = 0;
    localparam int CI_SEL  = 1;
    localparam int CI_RDEN = 2;
    localparam int CI_WREN = 3;
    localparam int CI_ALAT = 4;
    localparam int CI_BCLK = 5;
    localparam int NCTRL   = 6;

    // Classify one bus cycle from the sampled active-low pins.
    function automatic bus_op_t classify(input logic hrst_n, input logic sel_n,
                                         input logic rden_n, input logic wren_n);
        bus_op_t op;
        if (!hrst_n)                op = OP_RESET;
        else if (sel_n)             op = OP_STANDBY;
        else if (!wren_n && rden_n) op = OP_WRITE;
        else if (!rden_n && wren_n) op = OP_READ;
        else                        op = OP_OUTDIS;
        return op;
    endfunction

endpackage

// File: rtl/fbf_sync.sv
// Two-flop synchronizer bank, one chain per bit.
// Assumes each bit is independent; multi-bit buses must be stable
// around the sampling points (quasi-static address and data).
module fbf_sync #(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage resampling of one pin into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= INIT[i];
                stab_q <= INIT[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end

        assign q[i] = stab_q;
    end

endmodule

// File: rtl/fbf_addr_latch.sv
// Address latch with asynchronous (transparent) and synchronous
// (first-event) modes. Assumes synchronized inputs and their values
// one cycle earlier for edge detection.
module fbf_addr_latch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sync,
    input  logic          hrst_s,
    input  logic          sel_s,
    input  logic          wren_s,
    input  logic          alat_s,
    input  logic          alat_p,
    input  logic          bclk_s,
    input  logic          bclk_p,
    input  logic [AW-1:0] addr_s,
    output logic [AW-1:0] addr_q,
    output logic          sync_cap
);

    logic armed_q;
    logic alat_rise;
    logic alat_fall;
    logic bclk_rise;
    logic cap_allowed;

    assign alat_rise   = alat_s & ~alat_p;
    assign alat_fall   = ~alat_s & alat_p;
    assign bclk_rise   = bclk_s & ~bclk_p;
    assign cap_allowed = ~sel_s & wren_s & hrst_s;

    // First qualifying event of an armed window captures in sync mode.
    assign sync_cap = mode_sync & armed_q & cap_allowed
                    & (alat_rise | (bclk_rise & ~alat_s));

    // Arm on each new address-valid window, disarm after a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)          armed_q <= 1'b1;
        else if (!hrst_s)    armed_q <= 1'b1;
        else if (sync_cap)   armed_q <= 1'b0;
        else if (alat_fall)  armed_q <= 1'b1;
    end

    // Latch storage: follows pins in async mode, loads on capture in sync.
    always_ff @(posedge clk) begin
        if (!rst_n)                     addr_q <= '0;
        else if (!mode_sync && !alat_s) addr_q <= addr_s;
        else if (sync_cap)              addr_q <= addr_s;
    end

endmodule

// File: rtl/fbf_write_cap.sv
// Write capture: holds the pins during a write window and issues one
// strobe when the window closes. Assumes the cycle class of this and
// the previous cycle plus rising-edge flags of select and write enable.
module fbf_write_cap
    import fbf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_op_t       op,
    input  bus_op_t       op_prev,
    input  logic          sel_rise,
    input  logic          wren_rise,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data
);

    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic          close_evt;

    // Window closes on the first rising enable after a write cycle.
    assign close_evt = (op_prev == OP_WRITE) && (op != OP_RESET)
                     && (sel_rise || wren_rise);

    // Track the pins for as long as the write window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
        end else if (op == OP_WRITE) begin
            hold_addr <= addr_s;
            hold_data <= data_s;
        end
    end

    // Emit the single-cycle command strobe with the held values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= close_evt;
            if (close_evt) begin
                cmd_addr <= hold_addr;
                cmd_data <= hold_data;
            end
        end
    end

endmodule

// File: rtl/fbf_read_path.sv
// Read path: output enables for data and stall, and the stall counter
// started by a synchronous capture. Assumes mem_rdata is valid in the
// same cycle as the latched address.
module fbf_read_path
    import fbf_pkg::*;
#(
    parameter int DW         = 16,
    parameter int RD_LATENCY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hrst_s,
    input  bus_op_t       op,
    input  logic          mode_sync,
    input  logic          sync_cap,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          stall_out,
    output logic          stall_oe
);

    localparam int CW = $clog2(RD_LATENCY + 1);

    logic [CW-1:0] lat_cnt;

    // Count the initial latency; the reset pin abandons it.
    always_ff @(posedge clk) begin
        if (!rst_n)              lat_cnt <= '0;
        else if (!hrst_s)        lat_cnt <= '0;
        else if (sync_cap)       lat_cnt <= CW'(RD_LATENCY);
        else if (lat_cnt != '0)  lat_cnt <= lat_cnt - 1'b1;
    end

    assign data_out  = mem_rdata;
    assign data_oe   = (op == OP_READ);
    assign stall_oe  = (op == OP_READ) && mode_sync;
    assign stall_out = (lat_cnt != '0);

endmodule

// File: rtl/flash_bus_front.sv
// Device-side front end of a parallel flash bus. Synchronizes all pins,
// classifies the cycle, latches the address, captures writes and drives
// the read enables. Assumes clk is several times faster than any pin
// transition and that cfg_sync only changes while the bus is idle.
module flash_bus_front
    import fbf_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int RD_LATENCY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sync,
    input  logic          pin_hrst_n,
    input  logic          pin_sel_n,
    input  logic          pin_rden_n,
    input  logic          pin_wren_n,
    input  logic          pin_alat_n,
    input  logic          pin_bclk,
    input  logic [AW-1:0] pin_addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          stall_out,
    output logic          stall_oe,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data,
    output logic [2:0]    bus_op
);

    localparam int SW = NCTRL + AW + DW;
    localparam logic [SW-1:0] SYNC_INIT = {{(AW + DW){1'b0}}, {NCTRL{1'b1}}};

    logic [SW-1:0]    pin_bus;
    logic [SW-1:0]    pin_s;
    logic [NCTRL-1:0] ctrl_s;
    logic [AW-1:0]    addr_s;
    logic [DW-1:0]    data_s;
    logic             sel_p, wren_p, alat_p, bclk_p;
    logic             mode_q;
    logic             sync_cap;
    bus_op_t          op;
    bus_op_t          op_prev;

    assign pin_bus = {data_in, pin_addr, pin_bclk, pin_alat_n,
                      pin_wren_n, pin_rden_n, pin_sel_n, pin_hrst_n};

    fbf_sync #(.W(SW), .INIT(SYNC_INIT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_bus),
        .q     (pin_s)
    );

    assign ctrl_s = pin_s[NCTRL-1:0];
    assign addr_s = pin_s[NCTRL +: AW];
    assign data_s = pin_s[NCTRL + AW +: DW];

    assign op     = classify(ctrl_s[CI_HRST], ctrl_s[CI_SEL],
                             ctrl_s[CI_RDEN], ctrl_s[CI_WREN]);
    assign bus_op = op;

    // One-cycle history of edge-sensitive pins and of the cycle class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_p   <= 1'b1;
            wren_p  <= 1'b1;
            alat_p  <= 1'b1;
            bclk_p  <= 1'b1;
            op_prev <= OP_STANDBY;
        end else begin
            sel_p   <= ctrl_s[CI_SEL];
            wren_p  <= ctrl_s[CI_WREN];
            alat_p  <= ctrl_s[CI_ALAT];
            bclk_p  <= ctrl_s[CI_BCLK];
            op_prev <= op;
        end
    end

    // Mode register: async after reset, reloaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (op == OP_STANDBY || op == OP_RESET)
            mode_q <= cfg_sync;
    end

    fbf_addr_latch #(.AW(AW)) u_alat (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sync (mode_q),
        .hrst_s    (ctrl_s[CI_HRST]),
        .sel_s     (ctrl_s[CI_SEL]),
        .wren_s    (ctrl_s[CI_WREN]),
        .alat_s    (ctrl_s[CI_ALAT]),
        .alat_p    (alat_p),
        .bclk_s    (ctrl_s[CI_BCLK]),
        .bclk_p    (bclk_p),
        .addr_s    (addr_s),
        .addr_q    (mem_addr),
        .sync_cap  (sync_cap)
    );

    fbf_write_cap #(.AW(AW), .DW(DW)) u_wcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .op_prev   (op_prev),
        .sel_rise  (ctrl_s[CI_SEL] & ~sel_p),
        .wren_rise (ctrl_s[CI_WREN] & ~wren_p),
        .addr_s    (addr_s),
        .data_s    (data_s),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    fbf_read_path #(.DW(DW), .RD_LATENCY(RD_LATENCY)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .hrst_s    (ctrl_s[CI_HRST]),
        .op        (op),
        .mode_sync (mode_q),
        .sync_cap  (sync_cap),
        .mem_rdata (mem_rdata),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .stall_out (stall_out),
        .stall_oe  (stall_oe)
    );

endmodule

// File: rtl/fbf_checker.sv
// Protocol checker for flash_bus_front, attached with bind.
// Assumes the bus_op encoding of fbf_pkg.
module fbf_checker
    import fbf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op,
    input logic       data_oe,
    input logic       stall_oe,
    input logic       stall_out,
    input logic       cmd_valid,
    input logic       mode_q,
    input logic       sync_cap
);

    // R4: a command strobe never lasts more than one cycle.
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R3: a strobe only follows a write cycle.
    p_strobe_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(op, 2) == OP_WRITE);

    // R7: the stall pin is never driven while the data bus is released.
    p_stall_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_oe |-> data_oe);

    // R8: reset class releases everything and ends any stall.
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESET) |-> (!data_oe && !stall_oe));
    p_reset_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESET) |=> !stall_out);

    // R10: a stall only starts right after a synchronous capture.
    p_stall_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_out) |-> $past(sync_cap));

    // R6: captures of the first-event kind only happen in sync mode.
    p_cap_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_cap |-> mode_q);

    // R11: the mode holds while a bus cycle is active.
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(op == OP_RESET || op == OP_STANDBY) |=> $stable(mode_q));

endmodule

bind flash_bus_front fbf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (bus_op),
    .data_oe   (data_oe),
    .stall_oe  (stall_oe),
    .stall_out (stall_out),
    .cmd_valid (cmd_valid),
    .mode_q    (mode_q),
    .sync_cap  (sync_cap)
);

// File: tb/sim_flash_bus_front.sv
// Bench for flash_bus_front: sweeps all control pin combinations in both
// modes and walks address latch, write capture and stall scenarios.
module sim_flash_bus_front;

    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int LAT = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_sync = 1'b0;
    logic          p_hrst = 1'b1, p_sel = 1'b1, p_rden = 1'b1;
    logic          p_wren = 1'b1, p_alat = 1'b1, p_bclk = 1'b1;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_din = '0;
    logic [DW-1:0] data_out;
    logic          data_oe, stall_out, stall_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          cmd_valid;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [2:0]    bus_op;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    logic [AW-1:0] last_caddr = '0;
    logic [DW-1:0] last_cdata = '0;

    always #2 clk = ~clk;  // 250 MHz

    flash_bus_front #(.AW(AW), .DW(DW), .RD_LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync),
        .pin_hrst_n(p_hrst), .pin_sel_n(p_sel), .pin_rden_n(p_rden),
        .pin_wren_n(p_wren), .pin_alat_n(p_alat), .pin_bclk(p_bclk),
        .pin_addr(p_addr), .data_in(p_din),
        .data_out(data_out), .data_oe(data_oe),
        .stall_out(stall_out), .stall_oe(stall_oe),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .bus_op(bus_op)
    );

    function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
        return DW'(a * 3 + 16'h1234);
    endfunction

    assign mem_rdata = mem_f(mem_addr);

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            strobes++;
            last_caddr = cmd_addr;
            last_cdata = cmd_data;
        end
    end

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic r, input logic s, input logic o,
                            input logic w, input logic a);
        p_hrst = r; p_sel = s; p_rden = o; p_wren = w; p_alat = a;
    endtask

    function automatic int exp_op(input logic r, input logic s,
                                  input logic o, input logic w);
        if (!r) return 0;
        if (s) return 1;
        if (!w && o) return 4;
        if (!o && w) return 3;
        return 2;
    endfunction

    // Count stall-high samples over a fixed window.
    task automatic count_stall(input int win, output int n);
        n = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (stall_out) n++;
        end
    endtask

    task automatic bclk_pulse();
        p_bclk = 1'b0; settle(4);
        p_bclk = 1'b1;
    endtask

    task automatic sweep(input logic sync_mode);
        for (int i = 0; i < 32; i++) begin
            logic r, s, o, w, a;
            int e;
            r = i[0]; s = i[1]; o = i[2]; w = i[3]; a = i[4];
            set_ctrl(r, s, o, w, a);
            settle(5);
            e = exp_op(r, s, o, w);
            check(int'(bus_op), e, "R1 cycle class");
            check(int'(data_oe), int'(e == 3), "R2/R7/R8 data enable");
            check(int'(stall_oe), int'(sync_mode && e == 3), "R9 stall enable");
        end
        set_ctrl(1, 1, 1, 1, 1);
        settle(5);
    endtask

    initial begin : main
        int n;
        logic [AW-1:0] a0, a1;
        int s0;
        settle(5);
        rst_n = 1'b1;
        settle(4);
        // Reset state
        check(int'(bus_op), 1, "R8 standby after reset");
        check(int'(data_oe), 0, "R8 data released after reset");
        check(int'(stall_oe), 0, "R8 stall released after reset");
        check(int'(stall_out), 0, "R10 no stall after reset");
        check(strobes, 0, "R3 no strobe after reset");

        // Full control sweep, async then sync
        sweep(1'b0);
        cfg_sync = 1'b1; settle(5);
        sweep(1'b1);

        // R11: mode change during an active cycle is deferred
        cfg_sync = 1'b0; settle(5);
        set_ctrl(1, 0, 0, 1, 1); settle(5);
        cfg_sync = 1'b1; settle(5);
        check(int'(stall_oe), 0, "R11 mode held during read");
        set_ctrl(1, 1, 1, 1, 1); settle(5);
        set_ctrl(1, 0, 0, 1, 1); settle(5);
        check(int'(stall_oe), 1, "R11 mode loaded when idle");
        set_ctrl(1, 1, 1, 1, 1); cfg_sync = 1'b0; settle(5);

        // R5/R2: async transparent latch
        for (int k = 0; k < 8; k++) begin
            a0 = AW'(16'h0100 + k * 37);
            a1 = ~a0;
            p_addr = a0;
            set_ctrl(1, 0, 0, 1, 0); settle(5);
            check(int'(data_out), int'(mem_f(a0)), "R2/R5 transparent read");
            check(int'(data_oe), 1, "R2 read drives bus");
            p_alat = 1'b1; settle(4);
            p_addr = a1; settle(5);
            check(int'(data_out), int'(mem_f(a0)), "R5 latch holds");
            p_alat = 1'b0; settle(5);
            check(int'(data_out), int'(mem_f(a1)), "R5 follows again");
            p_alat = 1'b1; settle(3);
            set_ctrl(1, 1, 1, 1, 1); settle(4);
        end

        // R3/R4: write capture, three ways of closing the window
        for (int k = 0; k < 6; k++) begin
            a0 = AW'(16'h2000 + k * 113);
            p_addr = a0;
            p_din = DW'(16'hA500 + k * 7);
            s0 = strobes;
            set_ctrl(1, 0, 1, 0, 1); settle(5);
            check(int'(data_oe), 0, "R3 write keeps bus as input");
            if (k % 3 == 0) begin
                p_wren = 1'b1; settle(5);
                p_din = ~p_din; settle(5);
                p_sel = 1'b1;
            end else if (k % 3 == 1) begin
                p_sel = 1'b1; settle(5);
                p_din = ~p_din; settle(5);
                p_wren = 1'b1;
            end else begin
                p_sel = 1'b1; p_wren = 1'b1;
            end
            settle(6);
            check(strobes - s0, 1, "R4 one strobe per window");
            check(int'(last_caddr), int'(a0), "R3 strobe address");
            check(int'(last_cdata), int'(DW'(16'hA500 + k * 7)), "R3 strobe data");
        end

        // Known address in async, then switch to sync
        p_addr = 16'h0042;
        set_ctrl(1, 0, 0, 1, 0); settle(5);
        p_alat = 1'b1; settle(4);
        set_ctrl(1, 1, 1, 1, 1); cfg_sync = 1'b1; settle(5);

        // R6: alat low without clock edge does not capture
        a0 = 16'h0777;
        p_addr = a0;
        set_ctrl(1, 0, 0, 1, 0); settle(6);
        check(int'(data_out), int'(mem_f(16'h0042)), "R6 no capture without event");
        check(int'(stall_oe), 1, "R9 stall driven in sync read");
        // bus clock edge captures; stall lasts LAT cycles
        p_bclk = 1'b0; settle(4);
        p_bclk = 1'b1;
        count_stall(LAT + 10, n);
        check(n, LAT, "R10 stall length after clock capture");
        check(int'(data_out), int'(mem_f(a0)), "R6 clock edge capture");
        // further events in the same window are ignored
        a1 = 16'h0999;
        p_addr = a1; settle(3);
        bclk_pulse();
        count_stall(LAT + 10, n);
        check(n, 0, "R6 second clock edge ignored");
        p_alat = 1'b1; settle(6);
        check(int'(data_out), int'(mem_f(a0)), "R6 closing edge ignored");
        // new window closed by the alat rising edge alone
        p_alat = 1'b0; settle(5);
        p_alat = 1'b1;
        count_stall(LAT + 10, n);
        check(n, LAT, "R10 stall length after alat capture");
        check(int'(data_out), int'(mem_f(a1)), "R6 alat edge capture");

        // R6: no capture while select is high
        set_ctrl(1, 1, 1, 1, 1); settle(4);
        p_addr = 16'h0123;
        p_alat = 1'b0; settle(4);
        bclk_pulse(); settle(4);
        p_alat = 1'b1; settle(4);
        set_ctrl(1, 0, 0, 1, 1); settle(5);
        check(int'(data_out), int'(mem_f(a1)), "R6 deselected events ignored");

        // R8: reset pin aborts a stall in progress
        p_addr = 16'h0321;
        p_alat = 1'b0; settle(4);
        p_bclk = 1'b0; settle(4);
        p_bclk = 1'b1; settle(4);
        check(int'(stall_out), 1, "R10 stall running");
        p_hrst = 1'b0; settle(4);
        check(int'(stall_out), 0, "R8 reset pin ends stall");
        check(int'(bus_op), 0, "R8 reset class");
        check(int'(data_oe), 0, "R8 reset releases data");
        check(int'(stall_oe), 0, "R8 reset releases stall");
        set_ctrl(1, 1, 1, 1, 1); settle(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule